// File: doc/BRIEF.md
# Reset Cause Register with Watchdog Service

This block records which sources caused the most recent system reset and keeps a small watchdog counter next to it. The reset sequencer holds `sys_rst_i` high for as long as reset lasts and keeps the source lines steady for that whole time. On the clock edge where reset is released, the block loads an 8-bit flag word from those lines. The word then stays fixed until the next reset ends. Software reads the word on `flags_o`.

A bus write to the register never changes the flags. Each write cycle sampled while the block is running produces a one-cycle service pulse on `svc_o`, and that pulse clears the watchdog counter. If the counter runs out without being serviced, the block raises a sticky watchdog reset request. It remembers that request through the following reset, so the watchdog flag is set at the next capture.

A four-state machine controls the block:
- `ST_HOLD`: reset is held and no watchdog expiry is pending.
- `ST_HOLD_WD`: reset is held after a watchdog expiry.
- `ST_RUN`: normal operation, with the counter running.
- `ST_BITE`: the watchdog has expired and the reset request is asserted.

Its transitions are:
- Reset taken: any state goes to `ST_HOLD_WD` if it was `ST_BITE` or `ST_HOLD_WD`, and to `ST_HOLD` otherwise.
- Capture: `ST_HOLD` or `ST_HOLD_WD` goes to `ST_RUN` when reset is released.
- Expire: `ST_RUN` goes to `ST_BITE` when the counter sits at its last count and no service pulse is present.
- Stay: `ST_BITE` remains in `ST_BITE` until reset.

Top module: `rst_cause_reg`

## Requirements
- R1: Flag bit positions are: bit 7 power-on, bit 6 external pin, bit 5 watchdog, bit 4 illegal opcode, bit 3 illegal address, bit 1 low-voltage. Bits 2 and 0 always read 0.
- R2: The flags load only on the rising clock edge where `sys_rst_i` is sampled low while the machine is in `ST_HOLD` or `ST_HOLD_WD`. At every other edge they keep their value, including while reset is held and during bus writes.
- R3: If `por_i` is high at capture, the flags become 0x82 (power-on and low-voltage set), whatever the other sources are.
- R4: If neither `por_i` nor `dbg_i` is high at capture, each source flag copies its source line and all active sources are set together. A low-voltage-only reset gives 0x02.
- R5: If `dbg_i` is high and `por_i` is low at capture, every flag is cleared (0x00).
- R6: A write (`wr_i`) sampled in `ST_RUN` makes `svc_o` high for exactly the next cycle, one pulse per write cycle. Writes sampled in any other state give no pulse.
- R7: The counter is zero after capture. It increments on each `ST_RUN` cycle that has no service pulse, and a service pulse clears it. `wd_req_o` rises on the edge where the counter is at `WD_TERM-1` with no pulse, and stays high until reset.
- R8: The watchdog flag is set at capture exactly when the reset was entered from `ST_BITE`. It is clear after any reset not preceded by an expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| sys_rst_i | input | 1 | High while system reset is held; a falling value triggers capture |
| por_i | input | 1 | Power-on reset source |
| pin_i | input | 1 | External reset pin source |
| ilop_i | input | 1 | Illegal opcode reset source |
| ilad_i | input | 1 | Illegal address reset source |
| lvd_i | input | 1 | Low-voltage reset source |
| dbg_i | input | 1 | Debug-host forced reset source |
| wr_i | input | 1 | Bus write strobe to the register address |
| flags_o | output | 8 | Captured reset-cause flags |
| svc_o | output | 1 | One-cycle watchdog service pulse |
| wd_req_o | output | 1 | Sticky watchdog reset request |

## Verification
The bench targets source priority at the capture edge:
- It drives power-on together with debug and pin; a design that let debug or the other sources win would read 0x00 or 0x40 instead of 0x82.
- It drives several sources at once; a one-hot capture would drop some of their flags.

It also checks that the watchdog cause survives a reset that follows an expiry. A design that forgot the expiry while reset was held would clear bit 5. Writes land while reset is held, after expiry, and on the cycle just before the counter would expire. A design that changed flags on a write, pulsed outside `ST_RUN`, or cleared the counter one cycle late would show a mismatched pulse or request timing.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
    localparam int FLAG_W   = 8;
    localparam int POS_POR  = 7;
    localparam int POS_PIN  = 6;
    localparam int POS_WDOG = 5;
    localparam int POS_ILOP = 4;
    localparam int POS_ILAD = 3;
    localparam int POS_LVD  = 1;

    localparam logic [FLAG_W-1:0] POR_PATTERN =
        (FLAG_W'(1) << POS_POR) | (FLAG_W'(1) << POS_LVD);

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_HOLD_WD = 2'd1,
        ST_RUN     = 2'd2,
        ST_BITE    = 2'd3
    } cause_state_e;

    typedef struct packed {
        logic por;
        logic pin;
        logic ilop;
        logic ilad;
        logic lvd;
        logic dbg;
    } src_t;
endpackage

// File: rtl/rst_cause_fsm.sv
module rst_cause_fsm
    import rst_cause_pkg::*;
(
    input  logic clk_i,
    input  logic sys_rst_i,
    input  logic expire_i,
    output logic capture_o,
    output logic wd_cause_o,
    output logic run_o,
    output logic bite_o
);
    cause_state_e st_q, st_d;

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (sys_rst_i) begin
            unique case (st_q)
                ST_BITE, ST_HOLD_WD: st_d = ST_HOLD_WD;
                ST_HOLD, ST_RUN:     st_d = ST_HOLD;
                default:             st_d = ST_HOLD;
            endcase
        end else begin
            unique case (st_q)
                ST_HOLD, ST_HOLD_WD: st_d = ST_RUN;
                ST_RUN:              st_d = expire_i ? ST_BITE : ST_RUN;
                ST_BITE:             st_d = ST_BITE;
                default:             st_d = ST_HOLD;
            endcase
        end
    end

    always_comb begin
        capture_o  = 1'b0;
        wd_cause_o = 1'b0;
        run_o      = 1'b0;
        bite_o     = 1'b0;
        unique case (st_q)
            ST_HOLD:    capture_o = !sys_rst_i;
            ST_HOLD_WD: begin
                capture_o  = !sys_rst_i;
                wd_cause_o = 1'b1;
            end
            ST_RUN:     run_o  = 1'b1;
            ST_BITE:    bite_o = 1'b1;
            default:    capture_o = 1'b0;
        endcase
    end

    // R7: once expired, the request stays until reset
    assert_bite_sticky_R7: assert property (@(posedge clk_i) disable iff (sys_rst_i)
        bite_o |=> bite_o);

    // R2: a capture is always followed by normal running
    assert_capture_to_run_R2: assert property (@(posedge clk_i) disable iff (sys_rst_i)
        capture_o |=> run_o);
endmodule

// File: rtl/rst_cause_wdog.sv
module rst_cause_wdog #(
    parameter int WD_TERM = 16
) (
    input  logic clk_i,
    input  logic sys_rst_i,
    input  logic run_i,
    input  logic bite_i,
    input  logic wr_i,
    output logic svc_o,
    output logic expire_o
);
    localparam int CNT_W = $clog2(WD_TERM + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WD_TERM - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             svc_q;

    always_ff @(posedge clk_i) begin
        if (sys_rst_i) begin
            cnt_q <= '0;
            svc_q <= 1'b0;
        end else begin
            svc_q <= wr_i && run_i;
            if (!run_i || svc_q) cnt_q <= '0;
            else                 cnt_q <= cnt_q + 1'b1;
        end
    end

    assign svc_o    = svc_q;
    assign expire_o = run_i && !svc_q && (cnt_q == LAST);

    // R6: a service pulse only follows a sampled write
    assert_svc_from_write_R6: assert property (@(posedge clk_i) disable iff (sys_rst_i)
        svc_q |-> $past(wr_i));

    // R7: a service pulse empties the counter on the next edge
    assert_svc_clears_R7: assert property (@(posedge clk_i) disable iff (sys_rst_i)
        svc_q |=> (cnt_q == '0));

    // R7: expiry only from the last count
    assert_bite_at_last_R7: assert property (@(posedge clk_i) disable iff (sys_rst_i)
        $rose(bite_i) |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/rst_cause_flags.sv
module rst_cause_flags
    import rst_cause_pkg::*;
(
    input  logic              clk_i,
    input  logic              sys_rst_i,
    input  logic              capture_i,
    input  logic              wd_cause_i,
    input  src_t              src_i,
    output logic [FLAG_W-1:0] flags_o
);
    logic [FLAG_W-1:0] next_flags;
    logic [FLAG_W-1:0] flags_q;

    always_comb begin
        next_flags = '0;
        if (src_i.por) begin
            next_flags = POR_PATTERN;
        end else if (!src_i.dbg) begin
            next_flags[POS_PIN]  = src_i.pin;
            next_flags[POS_WDOG] = wd_cause_i;
            next_flags[POS_ILOP] = src_i.ilop;
            next_flags[POS_ILAD] = src_i.ilad;
            next_flags[POS_LVD]  = src_i.lvd;
        end
    end

    always_ff @(posedge clk_i) begin
        if (capture_i) flags_q <= next_flags;
    end

    assign flags_o = flags_q;

    assert_reserved_zero_R1: assert property (@(posedge clk_i) disable iff (sys_rst_i)
        !capture_i |-> (flags_q[2] == 1'b0 && flags_q[0] == 1'b0));

    assert_hold_R2: assert property (@(posedge clk_i) disable iff (sys_rst_i)
        !capture_i |=> $stable(flags_q));

    assert_por_pattern_R3: assert property (@(posedge clk_i) disable iff (sys_rst_i)
        (capture_i && src_i.por) |=> (flags_q == POR_PATTERN));

    assert_lvd_copy_R4: assert property (@(posedge clk_i) disable iff (sys_rst_i)
        (capture_i && !src_i.por && !src_i.dbg) |=> (flags_q[POS_LVD] == $past(src_i.lvd)));

    assert_debug_clear_R5: assert property (@(posedge clk_i) disable iff (sys_rst_i)
        (capture_i && src_i.dbg && !src_i.por) |=> (flags_q == '0));

    assert_wd_flag_R8: assert property (@(posedge clk_i) disable iff (sys_rst_i)
        (capture_i && !src_i.por && !src_i.dbg) |=> (flags_q[POS_WDOG] == $past(wd_cause_i)));
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
    import rst_cause_pkg::*;
#(
    parameter int WD_TERM = 16
) (
    input  logic              clk_i,
    input  logic              sys_rst_i,
    input  logic              por_i,
    input  logic              pin_i,
    input  logic              ilop_i,
    input  logic              ilad_i,
    input  logic              lvd_i,
    input  logic              dbg_i,
    input  logic              wr_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic              svc_o,
    output logic              wd_req_o
);
    logic capture, wd_cause, run, bite, expire;
    src_t src;

    assign src = '{por: por_i, pin: pin_i, ilop: ilop_i, ilad: ilad_i, lvd: lvd_i, dbg: dbg_i};

    rst_cause_fsm u_fsm (
        .clk_i      (clk_i),
        .sys_rst_i  (sys_rst_i),
        .expire_i   (expire),
        .capture_o  (capture),
        .wd_cause_o (wd_cause),
        .run_o      (run),
        .bite_o     (bite)
    );

    rst_cause_wdog #(.WD_TERM(WD_TERM)) u_wdog (
        .clk_i     (clk_i),
        .sys_rst_i (sys_rst_i),
        .run_i     (run),
        .bite_i    (bite),
        .wr_i      (wr_i),
        .svc_o     (svc_o),
        .expire_o  (expire)
    );

    rst_cause_flags u_flags (
        .clk_i      (clk_i),
        .sys_rst_i  (sys_rst_i),
        .capture_i  (capture),
        .wd_cause_i (wd_cause),
        .src_i      (src),
        .flags_o    (flags_o)
    );

    assign wd_req_o = bite;

    // R6: a write never disturbs the captured flags
    assert_write_keeps_flags_R6: assert property (@(posedge clk_i) disable iff (sys_rst_i)
        (wr_i && !capture) |=> $stable(flags_o));
endmodule

// File: tb/rst_cause_reg_test.sv
module rst_cause_reg_test;
    localparam int TERM = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst = 1'b1, por = 1'b0, pin = 1'b0, ilop = 1'b0, ilad = 1'b0, lvd = 1'b0, dbg = 1'b0, wr = 1'b0;
    logic [7:0] flags;
    logic svc, wdreq;

    rst_cause_reg #(.WD_TERM(TERM)) uut (
        .clk_i(clk), .sys_rst_i(rst), .por_i(por), .pin_i(pin), .ilop_i(ilop),
        .ilad_i(ilad), .lvd_i(lvd), .dbg_i(dbg), .wr_i(wr),
        .flags_o(flags), .svc_o(svc), .wd_req_o(wdreq)
    );

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;
    string ftag = "R3";

    // Behavioural reference: 0 hold, 1 hold after expiry, 2 running, 3 expired
    int m_st = 0;
    int m_cnt = 0;
    bit m_svc = 1'b0, m_valid = 1'b0, m_started = 1'b0;
    logic [7:0] m_flags = 8'h00;

    always @(posedge clk) begin
        int nst;
        bit nsvc;
        nst = m_st;
        nsvc = 1'b0;
        if (rst) begin
            nst = (m_st == 1 || m_st == 3) ? 1 : 0;
            m_cnt = 0;
        end else if (m_st <= 1) begin
            if (por)      m_flags = 8'h82;
            else if (dbg) m_flags = 8'h00;
            else          m_flags = {1'b0, pin, (m_st == 1), ilop, ilad, 1'b0, lvd, 1'b0};
            m_valid = 1'b1;
            m_cnt = 0;
            nst = 2;
        end else if (m_st == 2) begin
            nsvc = wr;
            if (m_svc) m_cnt = 0;
            else begin
                if (m_cnt == TERM - 1) nst = 3;
                m_cnt++;
            end
        end
        m_svc = nsvc;
        m_st = nst;
        m_started = 1'b1;
    end

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (m_started && !done) begin
            chk(svc === m_svc, "R6", {7'd0, svc}, {7'd0, m_svc});
            chk(wdreq === (m_st == 3), "R7", {7'd0, wdreq}, {7'd0, (m_st == 3)});
            if (m_valid) begin
                chk(flags === m_flags, ftag, flags, m_flags);
                chk(flags[2] == 1'b0 && flags[0] == 1'b0, "R1", flags, flags & 8'hFA);
            end
        end
    end

    // sources packed as {por, pin, ilop, ilad, lvd, dbg}
    task automatic do_reset(input logic [5:0] s, input int cyc, input bit wr_inside);
        @(negedge clk);
        {por, pin, ilop, ilad, lvd, dbg} = s;
        rst = 1'b1;
        for (int i = 0; i < cyc; i++) begin
            wr = wr_inside && (i == 1);
            @(negedge clk);
        end
        wr = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        {por, pin, ilop, ilad, lvd, dbg} = 6'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_burst(input int n);
        wr = 1'b1;
        for (int i = 0; i < n; i++) @(negedge clk);
        wr = 1'b0;
    endtask

    initial begin
        // R3: first power-on together with low-voltage
        ftag = "R3";
        por = 1'b1; lvd = 1'b1;
        idle(4);
        rst = 1'b0;
        @(negedge clk);
        por = 1'b0; lvd = 1'b0;
        // R2 and R6: serviced running, flags unchanged by writes
        ftag = "R2";
        for (int k = 0; k < 6; k++) begin write_burst(1); idle(3); end
        write_burst(3);
        idle(TERM - 1);
        write_burst(1);
        idle(4);
        // R2: write during reset gives no pulse; pin cause
        ftag = "R4";
        do_reset(6'b010000, 4, 1'b1);
        idle(3);
        do_reset(6'b000010, 3, 1'b0);   // R4: low-voltage only -> 0x02
        idle(3);
        do_reset(6'b011100, 3, 1'b0);   // R4: several sources -> 0x58
        idle(3);
        ftag = "R3";
        do_reset(6'b110001, 3, 1'b0);   // R3: power-on beats debug
        idle(3);
        ftag = "R5";
        do_reset(6'b010011, 3, 1'b0);   // R5: debug clears
        idle(3);
        // R7/R8: let the watchdog expire, write while expired
        ftag = "R8";
        idle(TERM + 3);
        write_burst(2);
        idle(2);
        do_reset(6'b000000, 3, 1'b0);   // R8: 0x20
        idle(2);
        do_reset(6'b000000, 3, 1'b0);   // R8: 0x00
        idle(TERM + 2);
        do_reset(6'b001000, 2, 1'b0);   // R8 with illegal opcode -> 0x30
        idle(TERM + 2);
        ftag = "R5";
        do_reset(6'b000001, 2, 1'b0);   // R5: debug after expiry -> 0x00
        idle(4);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            n_run++;
            $display("FAIL timeout: actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule